// File: doc/BRIEF.md
# Boot Image Download Sequencer

This block sits on the host side of a co-processor link. It reads a packed boot image from a word-addressed source memory and replays it as a stream of writes into the slave's memory-access port. The slave port has two host-visible locations: one that latches the destination address and one that carries data. The slave increments the destination address by itself after each data word.

The image is a run of segments. Each segment is a 16-bit word count, then a destination address word, then that many data words. A 24-bit program opcode fills two words: the upper 16 bits first, then the low byte right-justified with a zero upper byte. Bit 14 of the address word selects data memory when set and program memory when clear. A count word of 0xFFFF ends the image.

A boot image puts the restart-vector segment last, just before the terminator. That segment has count 2, address 0x0000 and one split opcode. Writing it last lets the slave start running only once everything else is in place. The slave reports activity on a busy line. The sequencer waits for that line to be low before every host write, and again after every data write before it fetches more of the image.

Top module: `boot_dl_seq`

## Requirements
- R1: While reset is held, and afterwards until `start` is seen, `done`, `host_wr` and `src_rd_en` are all low.
- R2: A `start` pulse seen in the idle or finished state begins reading at source word 0. Each read advances the source address by exactly one word, so the whole image is read in ascending order.
- R3: A segment with a nonzero count N produces one write to location select 2 (address latch) and then N writes to location select 0 (data). The data words go out in image order. Each `host_wr` is a single-cycle strobe.
- R4: `host_wr` is never high while `slave_busy` is high. After a data write, no further source read is issued until `slave_busy` has been seen low.
- R5: The address latch write carries the address word with bit 15 forced to 0 and bits 14..0 unchanged, so bit 14 (the data-memory select) passes through.
- R6: A segment whose count is 0 still consumes its address word from the source. It produces no host write at all, and the next word read is treated as the next count.
- R7: A count word equal to 0xFFFF ends the download. `done` rises, no further source read or host write occurs, and `done` stays high until the next `start`.
- R8: A `start` pulse seen while a download is in progress has no effect on the read or write sequence.
- R9: Segments are replayed strictly in image order. A trailing restart segment (count 2, address 0x0000) is therefore the last thing written before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a download |
| done | output | 1 | High once the terminator has been read, until the next start |
| src_rd_en | output | 1 | Source memory read request; data is returned on the next cycle |
| src_addr | output | SRC_AW | Source word address |
| src_rdata | input | 16 | Source read data, valid the cycle after the request |
| host_wr | output | 1 | Single-cycle write strobe to the slave port |
| host_loc | output | 2 | Location select: 0 = data, 2 = address latch |
| host_wdata | output | 16 | Write data to the slave port |
| slave_busy | input | 1 | Slave busy/acknowledge, high while the slave is busy |

## Verification
Two events can coincide here. The slave's busy line can drop in the very cycle the sequencer is deciding whether to write, and a write strobe can land on the cycle where a previous write's busy window would still be open. The bench models a slave that raises busy for a programmable number of cycles after each strobe. It replays the same image with busy windows of zero, one and three cycles, and holds busy high artificially before the first latch. Any strobe or post-data fetch that meets a high busy line is counted as a violation. The write log must match the expected sequence exactly in every case.

// File: rtl/boot_dl_pkg.sv
package boot_dl_pkg;
  localparam int WORD_W = 16;
  localparam int DADR_W = 15;
  localparam int LOC_W  = 2;

  localparam logic [LOC_W-1:0] LOC_DATA  = 2'd0;
  localparam logic [LOC_W-1:0] LOC_LATCH = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CNT_RQ, ST_CNT_CP, ST_CNT_EV,
    ST_ADR_RQ, ST_ADR_CP, ST_ADR_WT, ST_ADR_WR,
    ST_DAT_RQ, ST_DAT_CP, ST_DAT_WT, ST_DAT_WR,
    ST_DAT_PS, ST_DONE
  } seq_state_t;

  // Destination address as written to the latch location: upper bits cleared.
  function automatic logic [WORD_W-1:0] latch_word(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] m;
    m = '0;
    m[DADR_W-1:0] = w[DADR_W-1:0];
    return m;
  endfunction

  function automatic logic is_term(input logic [WORD_W-1:0] w,
                                   input logic [WORD_W-1:0] term);
    return w == term;
  endfunction
endpackage

// File: rtl/bdl_fetch.sv
module bdl_fetch #(
  parameter int SRC_AW = 8,
  parameter int WORD_W = 16,
  parameter logic [SRC_AW-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              req,
  input  logic              cap,
  input  logic [WORD_W-1:0] rdata,
  output logic              rd_en,
  output logic [SRC_AW-1:0] addr,
  output logic [WORD_W-1:0] word_q
);
  logic [SRC_AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= BASE;
      word_q <= '0;
    end else begin
      if (restart)  ptr_q <= BASE;
      else if (req) ptr_q <= ptr_q + 1'b1;
      if (cap) word_q <= rdata;
    end
  end

  assign rd_en = req;
  assign addr  = ptr_q;

  // R2: each fetch moves the pointer by one word
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !restart) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/bdl_count.sv
module bdl_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= val;
    else if (dec)  rem_q <= rem_q - 1'b1;
  end

  assign zero = (rem_q == '0);

  // R3: never more data writes than the count allows
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (rem_q != '0));
endmodule

// File: rtl/bdl_hostbus.sv
module bdl_hostbus
  import boot_dl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_latch,
  input  logic              wr_data,
  input  logic [WORD_W-1:0] word,
  input  logic              slave_busy,
  output logic              host_wr,
  output logic [LOC_W-1:0]  host_loc,
  output logic [WORD_W-1:0] host_wdata
);
  assign host_wr    = wr_latch | wr_data;
  assign host_loc   = wr_latch ? LOC_LATCH : LOC_DATA;
  assign host_wdata = wr_latch ? latch_word(word) : word;

  // R4: no strobe into a busy slave
  a_r4_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |-> !slave_busy);
  // R5: latch word has bit 15 clear
  a_r5_latch_b15: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_loc == LOC_LATCH) |-> !host_wdata[WORD_W-1]);
  // R3: strobe lasts one cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> !host_wr);
endmodule

// File: rtl/boot_dl_seq.sv
module boot_dl_seq
  import boot_dl_pkg::*;
#(
  parameter int SRC_AW = 8,
  parameter logic [15:0] TERM = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              src_rd_en,
  output logic [SRC_AW-1:0] src_addr,
  input  logic [15:0]       src_rdata,
  output logic              host_wr,
  output logic [1:0]        host_loc,
  output logic [15:0]       host_wdata,
  input  logic              slave_busy
);
  seq_state_t st_q, st_d;

  logic [WORD_W-1:0] word_q;
  logic cnt_zero;
  logic ev_restart, ev_req, ev_cap, ev_load, ev_dec, ev_wr_latch, ev_wr_data;

  assign ev_restart  = (st_q == ST_IDLE || st_q == ST_DONE) && start;
  assign ev_req      = (st_q == ST_CNT_RQ) || (st_q == ST_ADR_RQ) || (st_q == ST_DAT_RQ);
  assign ev_cap      = (st_q == ST_CNT_CP) || (st_q == ST_ADR_CP) || (st_q == ST_DAT_CP);
  assign ev_load     = (st_q == ST_CNT_EV) && !is_term(word_q, TERM);
  assign ev_wr_latch = (st_q == ST_ADR_WR);
  assign ev_wr_data  = (st_q == ST_DAT_WR);
  assign ev_dec      = ev_wr_data;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start) st_d = ST_CNT_RQ;
      ST_CNT_RQ: st_d = ST_CNT_CP;
      ST_CNT_CP: st_d = ST_CNT_EV;
      ST_CNT_EV: st_d = is_term(word_q, TERM) ? ST_DONE : ST_ADR_RQ;
      ST_ADR_RQ: st_d = ST_ADR_CP;
      ST_ADR_CP: st_d = ST_ADR_WT;
      ST_ADR_WT: begin
        if (cnt_zero)         st_d = ST_CNT_RQ;
        else if (!slave_busy) st_d = ST_ADR_WR;
      end
      ST_ADR_WR: st_d = ST_DAT_RQ;
      ST_DAT_RQ: st_d = ST_DAT_CP;
      ST_DAT_CP: st_d = ST_DAT_WT;
      ST_DAT_WT: if (!slave_busy) st_d = ST_DAT_WR;
      ST_DAT_WR: st_d = ST_DAT_PS;
      ST_DAT_PS: if (!slave_busy) st_d = cnt_zero ? ST_CNT_RQ : ST_DAT_RQ;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign done = (st_q == ST_DONE);

  bdl_fetch #(.SRC_AW(SRC_AW), .WORD_W(WORD_W), .BASE('0)) u_fetch (
    .clk(clk), .rst_n(rst_n), .restart(ev_restart), .req(ev_req), .cap(ev_cap),
    .rdata(src_rdata), .rd_en(src_rd_en), .addr(src_addr), .word_q(word_q)
  );

  bdl_count #(.CNT_W(WORD_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .val(word_q), .dec(ev_dec), .zero(cnt_zero)
  );

  bdl_hostbus u_bus (
    .clk(clk), .rst_n(rst_n), .wr_latch(ev_wr_latch), .wr_data(ev_wr_data),
    .word(word_q), .slave_busy(slave_busy),
    .host_wr(host_wr), .host_loc(host_loc), .host_wdata(host_wdata)
  );

  // R7: done holds until start
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R7: nothing moves once finished
  a_r7_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!src_rd_en && !host_wr));
  // R4: a fetch after a data write only once the slave is seen idle
  a_r4_post_data: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DAT_PS && slave_busy) |=> !src_rd_en);
  // R3: fetch and strobe never share a cycle
  a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_rd_en, host_wr}));
endmodule

// File: tb/boot_dl_seq_tb.sv
module boot_dl_seq_tb;
  localparam int NIMG = 18;
  localparam int NEXP = 12;

  // image: PM segment, zero-count segment, DM segment (bit 15 set in source), restart vector
  localparam logic [15:0] IMG [0:NIMG-1] = '{
    16'h0004, 16'h0001, 16'h1234, 16'h0056, 16'h789A, 16'h00BC,
    16'h0000, 16'h4010,
    16'h0003, 16'hC020, 16'hAAAA, 16'hBBBB, 16'hCCCC,
    16'h0002, 16'h0000, 16'hDEF0, 16'h0012,
    16'hFFFF};
  // expected writes {loc, data}
  localparam logic [17:0] EXP [0:NEXP-1] = '{
    {2'd2,16'h0001}, {2'd0,16'h1234}, {2'd0,16'h0056}, {2'd0,16'h789A}, {2'd0,16'h00BC},
    {2'd2,16'h4020}, {2'd0,16'hAAAA}, {2'd0,16'hBBBB}, {2'd0,16'hCCCC},
    {2'd2,16'h0000}, {2'd0,16'hDEF0}, {2'd0,16'h0012}};

  logic clk = 0, rst_n = 0, start = 0;
  logic done, src_rd_en, host_wr;
  logic [7:0] src_addr;
  logic [15:0] src_rdata, host_wdata;
  logic [1:0] host_loc;
  logic slave_busy;

  always #4 clk = ~clk;

  boot_dl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .src_rd_en(src_rd_en), .src_addr(src_addr), .src_rdata(src_rdata),
    .host_wr(host_wr), .host_loc(host_loc), .host_wdata(host_wdata),
    .slave_busy(slave_busy)
  );

  logic [15:0] mem [0:63];
  int lat = 0;
  logic force_busy = 0;
  int busy_cnt;
  logic [17:0] wlog [0:31];
  int nwr, nrd, v_wr_busy, v_rd_busy, v_rd_order, v_done_act;
  logic last_data;

  assign slave_busy = force_busy || (busy_cnt != 0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= 0; nwr <= 0; nrd <= 0; last_data <= 0;
      v_wr_busy <= 0; v_rd_busy <= 0; v_rd_order <= 0; v_done_act <= 0;
      src_rdata <= 16'h0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (host_wr) begin
        if (nwr < 32) wlog[nwr] <= {host_loc, host_wdata};
        nwr <= nwr + 1;
        if (slave_busy) v_wr_busy <= v_wr_busy + 1;
        busy_cnt <= lat;
        last_data <= (host_loc == 2'd0);
      end
      if (src_rd_en) begin
        src_rdata <= mem[src_addr[5:0]];
        if (src_addr != nrd[7:0]) v_rd_order <= v_rd_order + 1;
        nrd <= nrd + 1;
        if (slave_busy && last_data) v_rd_busy <= v_rd_busy + 1;
        last_data <= 0;
      end
      if (done && (src_rd_en || host_wr)) v_done_act <= v_done_act + 1;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, req, {31'b0, done}, 1);
  endtask

  task automatic run_image(input int l, input logic hold_busy, input logic mid_start);
    lat = l;
    do_reset();
    if (hold_busy) force_busy = 1;
    pulse_start();
    if (hold_busy) begin
      repeat (8) @(negedge clk);
      // R4: no latch write while the slave is held busy
      chk(nwr == 0, "R4 held busy", nwr, 0);
      force_busy = 0;
    end
    if (mid_start) begin
      repeat (12) @(negedge clk);
      pulse_start();  // R8: must be ignored
    end
    wait_done("R7 done");
    for (int i = 0; i < NEXP; i++)
      chk(wlog[i] == EXP[i], "R3 R5 R9 write", {14'b0, wlog[i]}, {14'b0, EXP[i]});
    chk(nwr == NEXP, "R6 R8 write count", nwr, NEXP);
    chk(nrd == NIMG && v_rd_order == 0, "R2 reads", nrd, NIMG);
    chk(v_wr_busy == 0 && v_rd_busy == 0, "R4 busy gating", v_wr_busy + v_rd_busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = (i < NIMG) ? IMG[i] : 16'hFFFF;
    // R1: reset state
    #2;
    chk(!done && !host_wr && !src_rd_en, "R1 in reset", {done, host_wr, src_rd_en}, 0);
    do_reset();
    repeat (4) @(negedge clk);
    chk(!done && !host_wr && !src_rd_en, "R1 idle", {done, host_wr, src_rd_en}, 0);

    run_image(0, 1'b0, 1'b0);
    run_image(1, 1'b0, 1'b0);
    run_image(3, 1'b1, 1'b1);

    // R7: done holds, nothing moves
    repeat (10) @(negedge clk);
    chk(done && v_done_act == 0, "R7 hold", {31'b0, done}, 1);

    // R7 terminator-only image, restarted from the done state
    mem[0] = 16'hFFFF;
    pulse_start();
    chk(!done, "R7 start clears done", {31'b0, done}, 0);
    wait_done("R7 term only");
    chk(nwr == NEXP, "R7 no writes", nwr, NEXP);
    do_reset();
    pulse_start();
    wait_done("R7 term only fresh");
    chk(nwr == 0 && nrd == 1, "R7 one read", nrd, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule